// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides whether an incoming Ethernet frame should be kept, using only its 48-bit destination address. The receive path feeds the six destination bytes into the block in wire order, marking the first byte with a start strobe. The block stores the address and runs a CRC-32 over it as the bytes arrive. One cycle after the sixth byte it gives a one-cycle decision pulse with an accept flag.

The decision depends on a 6-bit receive mode, a programmed station address and a 64-bin multicast hash table. The block recognises frames addressed to the station, broadcast frames and multicast frames. Multicast frames pass on a set of rules: all multicast, a hit in the hash table, or the IPv4 multicast prefix. A promiscuous bit accepts every frame.

A three-state machine controls the block. Its states are IDLE, COLLECT and DECIDE. A start with a valid byte moves IDLE to COLLECT, which is the transition "open". In COLLECT, a start with a valid byte begins a new address, which is the transition "restart". The sixth valid byte moves COLLECT to DECIDE, which is the transition "complete". DECIDE returns to IDLE, which is "retire". If a new start arrives in the DECIDE cycle, DECIDE goes to COLLECT instead, which is "chain".

Top module: `eth_addr_filter`

## Requirements
- R1: After reset `dec_valid_o` and `dec_accept_o` are low.
- R2: `dec_valid_o` is high for exactly one cycle, in the cycle after the sixth destination byte is sampled. `dec_accept_o` is low whenever `dec_valid_o` is low.
- R3: The first destination byte is address byte 0. `station_i[8k+7:8k]` holds station byte k, so word j `station_i[16j+15:16j]` carries byte 2j in bits 7:0 and byte 2j+1 in bits 15:8.
- R4: When `mode_i[3]` (promiscuous) is set, every frame is accepted, whatever the other bits and tables hold.
- R5: When bit 0 of byte 0 is clear (unicast), the frame is accepted only if `mode_i[0]` is set and all six bytes equal the station address.
- R6: An all-ones address is broadcast. Without `mode_i[3]`, it is accepted exactly when `mode_i[2]` is set, and no multicast rule applies to it.
- R7: A multicast frame (bit 0 of byte 0 set, and the address not all ones) is accepted when `mode_i[1]` is set.
- R8: A multicast frame is accepted when `mode_i[4]` is set and `hash_i[idx]` is 1. Hash word j occupies `hash_i[16j+15:16j]`. To form `idx`, a 32-bit register starts at all ones and takes the 48 address bits, byte 0 first and bit 0 of each byte first. For each bit, fb = reg[0] xor bit; the register shifts right by one; if fb is 1 it is XORed with 0xEDB88320. `idx` is bits 31:26 of the result, without inversion.
- R9: A multicast frame is accepted when `mode_i[5]` is set and its first three bytes are 0x01, 0x00, 0x5E and bit 7 of byte 3 is 0.
- R10: Bytes offered without a start while no address is being collected are ignored. A start in the middle of an address discards the partial address. Cycles with `byte_valid_i` low inside an address are skipped.
- R11: A start offered in the DECIDE cycle begins the next address with no lost byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid_i | input | 1 | `byte_i` carries a destination byte |
| start_i | input | 1 | Marks the first destination byte (qualified by `byte_valid_i`) |
| byte_i | input | 8 | Destination byte |
| mode_i | input | 6 | Receive mode bits 0..5 as defined in R4 to R9 |
| station_i | input | 48 | Station address, three 16-bit words |
| hash_i | input | 64 | Multicast hash table, four 16-bit words |
| dec_valid_o | output | 1 | Decision strobe |
| dec_accept_o | output | 1 | Frame accepted |

## Verification
A corrupted byte counter shows up as a decision pulse that comes early, late or twice, in the first frame after the fault. A corrupted address register or CRC register leaves the pulse timing correct but gives the wrong accept flag, in the same decision cycle. Such an error only shows for mode and address combinations whose outcome depends on the damaged bits. For that reason the bench crosses all 64 mode values with unicast, broadcast, IP-multicast and hashed-multicast addresses, against two complementary hash tables. In that sweep, every hash lookup is seen both as a hit and as a miss.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int HASH_BITS  = 6;
    localparam int HASH_BINS  = 1 << HASH_BITS;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF;

    // receive mode bit positions
    localparam int MB_OWN   = 0;
    localparam int MB_ALLMC = 1;
    localparam int MB_BCAST = 2;
    localparam int MB_PROMI = 3;
    localparam int MB_HASH  = 4;
    localparam int MB_IPMC  = 5;
    localparam int MODE_W   = 6;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2
    } filt_state_t;
endpackage

// File: rtl/addr_filt_crc.sv
module addr_filt_crc
    import addr_filt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             fresh_i,
    input  logic [7:0]       byte_i,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] nxt;

    assign seed = fresh_i ? CRC_INIT : crc_q;

    always_comb begin
        nxt = seed;
        for (int b = 0; b < 8; b++) begin
            if (nxt[0] ^ byte_i[b]) nxt = (nxt >> 1) ^ CRC_POLY;
            else                    nxt = nxt >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= CRC_INIT;
        else if (step_i) crc_q <= nxt;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/addr_filt_match.sv
module addr_filt_match
    import addr_filt_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [HASH_BITS-1:0] hidx_i,
    input  logic [MODE_W-1:0]    mode_i,
    input  logic [ADDR_W-1:0]    station_i,
    input  logic [HASH_BINS-1:0] hash_i,
    output logic                 accept_o
);
    logic is_bcast, is_mcast, own_hit, ip_mc, hash_hit;

    assign is_bcast = &addr_i;
    assign is_mcast = addr_i[0] && !is_bcast;
    assign own_hit  = (addr_i == station_i);
    assign ip_mc    = (addr_i[23:0] == 24'h5E0001) && !addr_i[31];
    assign hash_hit = hash_i[hidx_i];

    always_comb begin
        if (mode_i[MB_PROMI])
            accept_o = 1'b1;
        else if (is_bcast)
            accept_o = mode_i[MB_BCAST];
        else if (is_mcast)
            accept_o = mode_i[MB_ALLMC]
                     | (mode_i[MB_HASH] & hash_hit)
                     | (mode_i[MB_IPMC] & ip_mc);
        else
            accept_o = mode_i[MB_OWN] & own_hit;
    end
endmodule

// File: rtl/eth_addr_filter.sv
module eth_addr_filter
    import addr_filt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_valid_i,
    input  logic                 start_i,
    input  logic [7:0]           byte_i,
    input  logic [MODE_W-1:0]    mode_i,
    input  logic [ADDR_W-1:0]    station_i,
    input  logic [HASH_BINS-1:0] hash_i,
    output logic                 dec_valid_o,
    output logic                 dec_accept_o
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

    filt_state_t state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CRC_W-1:0]  crc;
    logic              opening, taking, raw_accept;

    // a start with a byte opens a new address in any state
    assign opening = byte_valid_i && start_i;
    assign taking  = opening || (byte_valid_i && state_q == ST_COLLECT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (opening) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (opening)                         state_d = ST_COLLECT;
                else if (byte_valid_i && cnt_q == LAST) state_d = ST_DECIDE;
            end
            ST_DECIDE:  state_d = opening ? ST_COLLECT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (taking) begin
                cnt_q <= opening ? CNT_W'(1) : cnt_q + CNT_W'(1);
                addr_q[(opening ? 0 : int'(cnt_q))*8 +: 8] <= byte_i;
            end
        end
    end

    addr_filt_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (taking),
        .fresh_i (opening),
        .byte_i  (byte_i),
        .crc_o   (crc)
    );

    addr_filt_match u_match (
        .addr_i    (addr_q),
        .hidx_i    (crc[CRC_W-1 -: HASH_BITS]),
        .mode_i    (mode_i),
        .station_i (station_i),
        .hash_i    (hash_i),
        .accept_o  (raw_accept)
    );

    always_comb begin
        dec_valid_o  = (state_q == ST_DECIDE);
        dec_accept_o = dec_valid_o && raw_accept;
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |=> !dec_valid_o); // R2
    AST_PULSE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> $past(byte_valid_i)); // R2
    AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_o |-> !dec_accept_o); // R2
    AST_PROMISC: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && mode_i[MB_PROMI]) |-> dec_accept_o); // R4
    AST_BCAST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && (&addr_q) && !mode_i[MB_PROMI]) |-> (dec_accept_o == mode_i[MB_BCAST])); // R6
    AST_UNICAST_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && !addr_q[0] && !mode_i[MB_PROMI] && addr_q != station_i) |-> !dec_accept_o); // R5
endmodule

// File: tb/eth_addr_filter_bench.sv
module eth_addr_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [5:0]  mode_i = 6'd0;
    logic [47:0] station_i = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
    logic [63:0] hash_i = 64'hA5C3_0F96_3C5A_F00F;
    logic        dec_valid_o, dec_accept_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    eth_addr_filter u_eth_addr_filter (
        .clk(clk), .rst_n(rst_n), .byte_valid_i(byte_valid_i), .start_i(start_i),
        .byte_i(byte_i), .mode_i(mode_i), .station_i(station_i), .hash_i(hash_i),
        .dec_valid_o(dec_valid_o), .dec_accept_o(dec_accept_o)
    );

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] r = 32'hFFFFFFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = r[0] ^ a[i];
            r = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r[31:26];
    endfunction

    function automatic logic model(input logic [5:0] m, input logic [47:0] a);
        if (m[3]) return 1'b1;
        if (&a) return m[2];
        if (a[0]) return m[1] | (m[4] & hash_i[hidx(a)])
                         | (m[5] & (a[23:0] == 24'h5E0001) & !a[31]);
        return m[0] & (a == station_i);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b (mode=%b)", req, act, exp, mode_i);
        end
    endtask

    // drives 6 bytes; returns at the negedge of the decision cycle
    task automatic send(input logic [47:0] a, input int gap_after);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            byte_valid_i = 1'b1;
            start_i      = (i == 0);
            byte_i       = a[8*i +: 8];
            if (i == gap_after) begin
                @(negedge clk);
                byte_valid_i = 1'b0; start_i = 1'b0;
                @(negedge clk);
                byte_valid_i = 1'b1;
                byte_i       = a[8*(i+1) +: 8];
                i++;
                if (i == 5) break;
            end
        end
        @(negedge clk);
        byte_valid_i = 1'b0; start_i = 1'b0;
    endtask

    task automatic frame(input logic [47:0] a, input string req);
        send(a, 99);
        chk({req, " valid"}, dec_valid_o, 1'b1);
        chk({req, " accept"}, dec_accept_o, model(mode_i, a));
        @(negedge clk);
        chk("R2 single pulse", dec_valid_o, 1'b0);
        chk("R2 accept gated", dec_accept_o, 1'b0);
    endtask

    initial begin
        logic [47:0] addrs [6];
        logic [47:0] hm;
        addrs[0] = station_i;                   // own unicast
        addrs[1] = 48'h665544332202;            // other unicast
        addrs[2] = 48'hFFFFFFFFFFFF;            // broadcast
        addrs[3] = 48'h010203_5E0001;           // IP multicast
        addrs[4] = 48'h0102_83_5E0001;          // prefix ok, byte3 bit7 set
        addrs[5] = 48'h9A7856341203;            // generic multicast
        repeat (3) @(negedge clk);
        chk("R1 reset valid", dec_valid_o, 1'b0);
        chk("R1 reset accept", dec_accept_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", dec_valid_o, 1'b0);

        // R4 R5 R6 R7 R8 R9 R3: every mode x address class, both hash tables
        for (int t = 0; t < 2; t++) begin
            hash_i = (t == 0) ? 64'hA5C3_0F96_3C5A_F00F : ~64'hA5C3_0F96_3C5A_F00F;
            for (int m = 0; m < 64; m++) begin
                mode_i = 6'(m);
                for (int k = 0; k < 6; k++) frame(addrs[k], "R4-9 sweep");
            end
        end

        // R8 targeted hash bins
        mode_i = 6'b010000;
        for (int v = 0; v < 16; v++) begin
            hm = {8'(v * 37), 8'(v * 11), 8'h42, 8'(v), 8'h10, 8'h33};
            hash_i = 64'd1 << hidx(hm);
            frame(hm, "R8 hash hit");
            hash_i = ~(64'd1 << hidx(hm));
            frame(hm, "R8 hash miss");
        end

        // R10 bytes without start ignored
        mode_i = 6'b001000;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            byte_valid_i = 1'b1; start_i = 1'b0; byte_i = 8'(i);
            @(negedge clk);
            chk("R10 no start ignored", dec_valid_o, 1'b0);
        end
        byte_valid_i = 1'b0;

        // R10 restart mid-address, then full own address
        mode_i = 6'b000001;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_valid_i = 1'b1; start_i = (i == 0); byte_i = 8'hEE;
        end
        @(negedge clk);
        chk("R10 partial no decision", dec_valid_o, 1'b0);
        frame(station_i, "R10 restart");

        // R10 gaps inside an address
        send(station_i, 2);
        chk("R10 gap valid", dec_valid_o, 1'b1);
        chk("R10 gap accept", dec_accept_o, 1'b1);
        @(negedge clk);

        // R11 back-to-back: start during the decision cycle
        send(station_i, 99);
        chk("R11 first valid", dec_valid_o, 1'b1);
        chk("R11 first accept", dec_accept_o, 1'b1);
        for (int i = 0; i < 6; i++) begin
            if (i > 0) @(negedge clk);
            byte_valid_i = 1'b1; start_i = (i == 0); byte_i = addrs[1][8*i +: 8];
        end
        @(negedge clk);
        byte_valid_i = 1'b0; start_i = 1'b0;
        chk("R11 second valid", dec_valid_o, 1'b1);
        chk("R11 second reject", dec_accept_o, 1'b0);
        @(negedge clk);
        chk("R2 pulse end", dec_valid_o, 1'b0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule